// File: doc/BRIEF.md
# Single-Accumulator Byte-Code Processor

This block is a very small processor built around one 8-bit accumulator. Program and data share a 32-byte memory inside the block. Every instruction is one byte. The upper three bits select the operation. The lower five bits hold either a memory address or a small signed constant. The core runs each instruction over three clock cycles: it fetches the byte, then steps the program counter, then executes. All data is 8-bit two's complement, and arithmetic wraps around without raising any flag.

A test environment fills the memory through a preload port while the core is held in reset. It then releases reset and watches the core through debug outputs for the program counter, the accumulator and the controller state. A combinational peek port reads back any memory byte. The usual layout puts code at address 0 and above, with data placed downward from 0x1F. A typical program evaluates an expression such as T = (-5 - A + B) XOR C in an endless loop, with T at 0x1F, A at 0x1E, B at 0x1D and C at 0x1C.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears the program counter and the accumulator to 0 and puts the controller in the fetch state (`dbg_state` = 0).
- R2: An instruction has its opcode in bits [7:5] and its operand in bits [4:0]. The controller steps through fetch (0), then decode (1), then execute (2), then back to fetch, so each instruction takes exactly three cycles. Opcodes: 000 load, 001 subtract, 010 add, 011 XOR, 100 store, 101 branch, 110 load immediate, 111 no-operation.
- R3: Load copies M[operand] into the accumulator. Load immediate copies the operand into the accumulator, sign-extended from 5 to 8 bits.
- R4: Add and subtract compute ACC + M[operand] and ACC - M[operand] modulo 256, and overflow has no other effect.
- R5: XOR replaces the accumulator with its bitwise XOR against M[operand].
- R6: Store writes the accumulator into M[operand], in the execute cycle only.
- R7: In decode, the program counter increments by 1 and wraps from 31 to 0. A branch then loads the program counter with its operand in execute.
- R8: No-operation changes neither the accumulator nor the memory. The accumulator changes only in the execute cycle of load, load immediate, add, subtract or XOR.
- R9: A preload write (`pre_we`) takes effect only at an edge where `rst_n` is low. At any other time it is ignored.
- R10: Memory contents are kept through reset.
- R11: `dbg_rdata` shows M[`dbg_raddr`] combinationally, and this includes values written by store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_we | input | 1 | Preload write enable, honoured only in reset |
| pre_addr | input | 5 | Preload address |
| pre_data | input | 8 | Preload data byte |
| dbg_raddr | input | 5 | Peek address |
| dbg_rdata | output | 8 | Memory byte at the peek address |
| dbg_pc | output | 5 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_state | output | 2 | Controller state: 0 fetch, 1 decode, 2 execute |

## Verification
The assertions assume that reset is held for at least one edge before the core runs. They also assume that the memory holds only known byte values, so every fetched opcode decodes to one of the eight defined operations. The stimulus preloads all 32 addresses while reset is held, before the first release. After that it changes data only in reset, apart from one preload pulse made on purpose while the core runs, to show that such a write is ignored. Operand values come from a seeded random source mixed with extreme signed pairs that overflow the add and the subtract.

// File: rtl/acc_pkg.sv
// Package: shared sizes, opcode and controller-state encodings for the
// single-accumulator core. Assumes one-byte instructions, opcode on top.
package acc_pkg;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 5;
    localparam int OP_W  = DATA_W - ADDR_W;
    localparam int DEPTH = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_LD  = 3'b000,
        OP_SUB = 3'b001,
        OP_ADD = 3'b010,
        OP_XOR = 3'b011,
        OP_ST  = 3'b100,
        OP_BR  = 3'b101,
        OP_LDI = 3'b110,
        OP_NOP = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2
    } state_e;
endpackage

// File: rtl/acc_mem.sv
// Unified program/data memory: register array with a core read port, a peek
// read port and one write port. Assumes preload writes come only while the
// core is held in reset; they take priority over core stores.
module acc_mem #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write port: preload in reset, otherwise core store; no reset of contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (pre_we) mem_q[pre_addr] <= pre_data;
        end else if (core_we) begin
            mem_q[core_addr] <= core_wdata;
        end
    end

    // Combinational read ports for the core and for observation.
    always_comb begin
        core_rdata = mem_q[core_addr];
        peek_rdata = mem_q[peek_addr];
    end
endmodule

// File: rtl/acc_ctrl.sv
// Fetch/decode/execute sequencer holding the program counter and the
// instruction register. Assumes a combinational memory read, so the
// instruction byte is valid in the same FETCH cycle.
module acc_ctrl #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output acc_pkg::state_e   state,
    output logic [ADDR_W-1:0] pc,
    output acc_pkg::op_e      ir_op,
    output logic [ADDR_W-1:0] ir_opd
);
    import acc_pkg::*;

    logic [DATA_W-1:0] ir_q;

    // Sequencer, program counter and instruction register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir_q  <= {OP_NOP, {ADDR_W{1'b0}}};
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir_q  <= mem_rdata;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    pc    <= pc + 1'b1;
                    state <= ST_EXEC;
                end
                default: begin
                    if (ir_op == OP_BR) pc <= ir_opd;
                    state <= ST_FETCH;
                end
            endcase
        end
    end

    // Field split and memory address/write selection.
    always_comb begin
        ir_op    = op_e'(ir_q[DATA_W-1:ADDR_W]);
        ir_opd   = ir_q[ADDR_W-1:0];
        mem_addr = (state == ST_FETCH) ? pc : ir_opd;
        mem_we   = rst_n && (state == ST_EXEC) && (ir_op == OP_ST);
    end
endmodule

// File: rtl/acc_dp.sv
// Accumulator datapath: computes the next accumulator value from the opcode,
// the operand and the memory byte. Assumes exec_en is high for exactly one
// cycle per instruction. Arithmetic wraps modulo 2**DATA_W.
module acc_dp #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  acc_pkg::op_e      op,
    input  logic [ADDR_W-1:0] opd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc
);
    import acc_pkg::*;
    localparam int EXT_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] acc_nxt;
    logic              acc_ld;

    // Result selection for each accumulator-writing opcode.
    always_comb begin
        acc_ld  = 1'b1;
        acc_nxt = acc;
        unique case (op)
            OP_LD:   acc_nxt = mem_rdata;
            OP_SUB:  acc_nxt = acc - mem_rdata;
            OP_ADD:  acc_nxt = acc + mem_rdata;
            OP_XOR:  acc_nxt = acc ^ mem_rdata;
            OP_LDI:  acc_nxt = {{EXT_W{opd[ADDR_W-1]}}, opd};
            default: acc_ld  = 1'b0;
        endcase
    end

    // Accumulator register, written only in execute.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc <= '0;
        else if (exec_en && acc_ld) acc <= acc_nxt;
    end
endmodule

// File: rtl/acc_core.sv
// Top of the single-accumulator core: ties the sequencer, the datapath and
// the unified memory together and exposes preload, peek and debug ports.
// Assumes the preload port is driven only while rst_n is low.
module acc_core #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic [ADDR_W-1:0] dbg_raddr,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_acc,
    output logic [1:0]        dbg_state
);
    import acc_pkg::*;

    state_e            st;
    op_e               ir_op;
    logic [ADDR_W-1:0] ir_opd;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] core_addr;
    logic              core_we;
    logic [DATA_W-1:0] core_rdata;
    logic [DATA_W-1:0] acc;

    acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mem_rdata(core_rdata), .mem_addr(core_addr),
        .mem_we(core_we), .state(st), .pc(pc), .ir_op(ir_op), .ir_opd(ir_opd)
    );

    acc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .exec_en(st == ST_EXEC), .op(ir_op),
        .opd(ir_opd), .mem_rdata(core_rdata), .acc(acc)
    );

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(acc), .core_rdata(core_rdata), .peek_addr(dbg_raddr),
        .peek_rdata(dbg_rdata)
    );

    // Debug outputs.
    always_comb begin
        dbg_pc    = pc;
        dbg_acc   = acc;
        dbg_state = st;
    end
endmodule

// File: rtl/acc_core_chk.sv
// Checker for acc_core: sequencing, program counter, accumulator and store
// properties. Assumes reset is held for at least one edge at start.
module acc_core_chk #(
    parameter int DATA_W = acc_pkg::DATA_W,
    parameter int ADDR_W = acc_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input acc_pkg::state_e   state,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input acc_pkg::op_e      op,
    input logic [ADDR_W-1:0] opd,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_we
);
    import acc_pkg::*;
    localparam int EXT_W = DATA_W - ADDR_W;

    logic is_exec;
    assign is_exec = (state == ST_EXEC);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && acc == '0 && state == ST_FETCH));

    p_fetch_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_DECODE);
    p_decode_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |=> state == ST_EXEC);
    p_exec_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXEC |=> state == ST_FETCH);

    p_ld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_LD) |=> acc == $past(mem_rdata));
    p_ldi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_LDI) |=> acc == {{EXT_W{$past(opd[ADDR_W-1])}}, $past(opd)});

    p_add_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_ADD) |=> acc == DATA_W'($past(acc) + $past(mem_rdata)));
    p_sub_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_SUB) |=> acc == DATA_W'($past(acc) - $past(mem_rdata)));

    p_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_XOR) |=> acc == ($past(acc) ^ $past(mem_rdata)));

    p_store_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (is_exec && op == OP_ST));
    p_store_issued_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_ST) |-> mem_we);

    p_pc_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |=> pc == ADDR_W'($past(pc) + 1'b1));
    p_pc_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_exec && op == OP_BR) |=> pc == $past(opd));
    p_pc_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> $stable(pc));

    p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_exec || op == OP_NOP || op == OP_ST || op == OP_BR) |=> $stable(acc));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(st), .pc(pc), .acc(acc), .op(ir_op),
    .opd(ir_opd), .mem_rdata(core_rdata), .mem_we(core_we)
);

// File: tb/acc_core_bench.sv
// Bench for acc_core: preloads programs, runs them and compares results with
// values computed by bench functions.
module acc_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [4:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [4:0] dbg_raddr = '0;
    logic [7:0] dbg_rdata;
    logic [4:0] dbg_pc;
    logic [7:0] dbg_acc;
    logic [1:0] dbg_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
        .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_state(dbg_state)
    );

    function automatic logic [7:0] ref_t(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        return (8'hFB - a + b) ^ c;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic peek(logic [4:0] a, output logic [7:0] v);
        dbg_raddr = a;
        #1;
        v = dbg_rdata;
    endtask

    task automatic poke(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_cycles(int n);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_vector(logic [7:0] a, logic [7:0] b, logic [7:0] c, bit twice);
        logic [7:0] v;
        logic [7:0] e;
        enter_reset();
        poke(5'h1E, a); poke(5'h1D, b); poke(5'h1C, c); poke(5'h1F, 8'h55);
        e = ref_t(a, b, c);
        run_cycles(18);
        peek(5'h1F, v);
        chk("R4 R5 R6 T value", v, e);
        chk("R3 R4 R5 acc equals T", dbg_acc, e);
        chk("R7 pc back at 0 after BR", {3'b0, dbg_pc}, 8'h00);
        if (twice) begin
            repeat (18) @(posedge clk);
            @(negedge clk);
            peek(5'h1F, v);
            chk("R7 second loop T", v, e);
            chk("R2 state fetch at loop start", {6'b0, dbg_state}, 8'h00);
        end
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        for (int i = 0; i < 32; i++) poke(5'(i), 8'h00);
        // R1: state in reset
        chk("R1 pc in reset", {3'b0, dbg_pc}, 8'h00);
        chk("R1 acc in reset", dbg_acc, 8'h00);
        chk("R1 state in reset", {6'b0, dbg_state}, 8'h00);

        // Directed program: LD, NOP, ST, LDI, ST, BR to 0x1F holding NOP
        poke(5'h00, 8'h1E); poke(5'h01, 8'hE0); poke(5'h02, 8'h9B);
        poke(5'h03, 8'hCF); poke(5'h04, 8'h9A); poke(5'h05, 8'hBF);
        poke(5'h1F, 8'hE0); poke(5'h1E, 8'h9C);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 decode after first edge", {6'b0, dbg_state}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R2 execute after second edge", {6'b0, dbg_state}, 8'h02);
        chk("R7 pc incremented in decode", {3'b0, dbg_pc}, 8'h01);
        @(posedge clk); @(negedge clk);
        chk("R3 LD result", dbg_acc, 8'h9C);
        chk("R2 fetch after third edge", {6'b0, dbg_state}, 8'h00);
        // R9: preload pulse while running is ignored
        pre_we = 1'b1; pre_addr = 5'h10; pre_data = 8'h77;
        @(posedge clk); @(negedge clk);
        pre_we = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 NOP keeps acc", dbg_acc, 8'h9C);
        peek(5'h10, v);
        chk("R9 preload ignored while running", v, 8'h00);
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk("R7 pc wraps 31 to 0", {3'b0, dbg_pc}, 8'h00);
        chk("R3 LDI sign extension positive", dbg_acc, 8'h0F);
        peek(5'h1B, v);
        chk("R6 R11 store of loaded value", v, 8'h9C);
        peek(5'h1A, v);
        chk("R6 store of immediate", v, 8'h0F);
        peek(5'h1F, v);
        chk("R8 NOP leaves memory", v, 8'hE0);

        // R10: memory kept through reset
        enter_reset();
        peek(5'h1B, v);
        chk("R10 memory kept in reset", v, 8'h9C);
        chk("R1 acc cleared by reset", dbg_acc, 8'h00);

        // Expression program: LDI -5, SUB A, ADD B, XOR C, ST T, BR 0
        poke(5'h00, 8'hDB); poke(5'h01, 8'h3E); poke(5'h02, 8'h5D);
        poke(5'h03, 8'h7C); poke(5'h04, 8'h9F); poke(5'h05, 8'hA0);
        t_vector(8'h05, 8'h0A, 8'h3C, 1'b1);
        t_vector(8'h7F, 8'h80, 8'h00, 1'b0); // R4 overflow
        t_vector(8'h80, 8'h7F, 8'hFF, 1'b0); // R4 overflow
        t_vector(8'h00, 8'h00, 8'h00, 1'b0);
        t_vector(8'hFF, 8'hFF, 8'hAA, 1'b0);
        t_vector(8'h80, 8'h80, 8'h80, 1'b1);
        for (int k = 0; k < 24; k++)
            t_vector(8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule